// File: doc/BRIEF.md
# Cache Maintenance Control Unit

This unit holds the control state for a small direct-mapped cache that sits in front of on-chip SRAM, one view for data and one for instructions. Software programs it through three 32-bit registers on a plain write/read register bus. The first is a bitmap that marks each 32 KB address region as cacheable or uncached. The second is a function-control word with a global enable and two whole-cache clean triggers. The third is a line-invalidate command word. The unit keeps one valid bit per line, for 128 lines of 32 bytes on each side. A refill engine outside the unit sets these bits when a line arrives. The unit also gives a combinational lookup: for a given address and side, it reports whether the address is cacheable and whether a resident line may serve it.

Maintenance commands are edge-triggered. A whole-side clean, or an invalidate of a single line, acts only when software moves the matching request bit from 0 to 1. Writing the bit as 1 when it already holds 1 does nothing. Software therefore writes 0 first and then the command. The data array, the memory refill path and prefetch are outside this unit.

Top module: `cmaint_unit`

## Requirements
- R1: After reset, all three registers read 0, every valid bit is clear, and no lookup reports cacheable or hit-eligible.
- R2: Register offsets: area map at 0xA50, which reads back all 32 written bits. Line invalidate at 0xA54, which reads back its last written 32-bit value. Function control at 0xA58, which reads back bits [2:0] as last written, with bits [31:3] reading 0. Any other offset reads 0.
- R3: The lookup reports cacheable exactly when control bit 0 (enable) is 1 and bit k of the area map is 1, where k is lookup address bits [19:15].
- R4: A refill pulse with side (0 = data, 1 = instruction) and line index sets that valid bit. A lookup reports hit-eligible exactly when it is cacheable and the valid bit is set for the requested side at index = address bits [11:5].
- R5: A write to function control that moves bit 1 from 0 to 1 clears all 128 data valid bits in that cycle. Instruction valid bits are unchanged.
- R6: A write that moves function-control bit 2 from 0 to 1 clears all 128 instruction valid bits. Data valid bits are unchanged.
- R7: A function-control write with a clean bit at 1, while that bit already holds 1, clears nothing.
- R8: A write to the invalidate register that moves bit 31 from 0 to 1 clears one data valid bit. The index is taken from bits [26:21] (address bits [10:5] carried in [26:16]), and the missing top index bit is 0. No other line is touched.
- R9: A write that moves invalidate bit 15 from 0 to 1 clears one instruction valid bit. The index is taken from bits [10:5], and the top index bit is 0.
- R10: Rewriting an invalidate command whose request bit already holds 1 clears nothing.
- R11: If a clean or line invalidate hits the same side and index as a refill in the same cycle, the bit ends clear. A refill to a different index in that cycle still sets its bit.
- R12: With enable at 0, every lookup reports neither cacheable nor hit-eligible, and the valid bits are kept. Setting enable again restores the hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte offset for write and read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| fill_valid | input | 1 | One-cycle refill-done pulse |
| fill_side | input | 1 | Refill side, 0 data, 1 instruction |
| fill_index | input | 7 | Refilled line index |
| lk_addr | input | 20 | Lookup byte address |
| lk_side | input | 1 | Lookup side, 0 data, 1 instruction |
| lk_cacheable | output | 1 | Address is cacheable under current settings |
| lk_hit_ok | output | 1 | Cacheable and indexed line valid |

## Verification
A refill from the memory side and a maintenance write from software can land in the same clock, both aimed at one valid bit. The bench provokes this by driving a refill pulse in the very cycle of an invalidate or clean write. It does so once with the same side and index, and once with a neighbouring index. Its behavioural model applies the refill first and the clear second, and every clock it compares the lookup outputs and the read data against that model. The bit must read as a miss in the first case and as a hit in the second.

// File: rtl/cmaint_pkg.sv
package cmaint_pkg;
  localparam int REG_AW = 12;
  localparam logic [REG_AW-1:0] OFF_AREA = 12'hA50;
  localparam logic [REG_AW-1:0] OFF_LINV = 12'hA54;
  localparam logic [REG_AW-1:0] OFF_CTRL = 12'hA58;

  localparam int CTL_W      = 3;
  localparam int CTL_EN     = 0;
  localparam int CTL_DCLEAN = 1;
  localparam int CTL_ICLEAN = 2;

  localparam int LINV_DREQ    = 31;
  localparam int LINV_DLSB    = 16;
  localparam int LINV_IREQ    = 15;
  localparam int LINV_ILSB    = 0;
  localparam int LINV_FIELD_W = 11;

  localparam int SIDE_D = 0;
  localparam int SIDE_I = 1;
  localparam int NSIDE  = 2;
endpackage

// File: rtl/cmaint_regs.sv
module cmaint_regs
  import cmaint_pkg::*;
#(
  parameter int MAP_W     = 32,
  parameter int IDX_W     = 7,
  parameter int LINE_LOG2 = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_wr,
  input  logic [REG_AW-1:0]            bus_addr,
  input  logic [31:0]                  bus_wdata,
  output logic [31:0]                  bus_rdata,
  output logic [MAP_W-1:0]             area_map,
  output logic                         enable,
  output logic [NSIDE-1:0]             clean_pulse,
  output logic [NSIDE-1:0]             linv_pulse,
  output logic [NSIDE-1:0][IDX_W-1:0]  linv_idx
);
  logic [MAP_W-1:0] map_q;
  logic [CTL_W-1:0] ctl_q;
  logic [31:0]      inv_q;
  logic wr_area, wr_ctl, wr_inv;
  logic [LINV_FIELD_W-1:0] fld_d, fld_i;

  assign wr_area = bus_wr && (bus_addr == OFF_AREA);
  assign wr_ctl  = bus_wr && (bus_addr == OFF_CTRL);
  assign wr_inv  = bus_wr && (bus_addr == OFF_LINV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q <= '0;
      ctl_q <= '0;
      inv_q <= '0;
    end else begin
      if (wr_area) map_q <= bus_wdata[MAP_W-1:0];
      if (wr_ctl)  ctl_q <= bus_wdata[CTL_W-1:0];
      if (wr_inv)  inv_q <= bus_wdata;
    end
  end

  // Rising-edge commands: act only when the stored bit was 0.
  assign clean_pulse[SIDE_D] = wr_ctl && bus_wdata[CTL_DCLEAN] && !ctl_q[CTL_DCLEAN];
  assign clean_pulse[SIDE_I] = wr_ctl && bus_wdata[CTL_ICLEAN] && !ctl_q[CTL_ICLEAN];
  assign linv_pulse[SIDE_D]  = wr_inv && bus_wdata[LINV_DREQ] && !inv_q[LINV_DREQ];
  assign linv_pulse[SIDE_I]  = wr_inv && bus_wdata[LINV_IREQ] && !inv_q[LINV_IREQ];

  // Carried address field shifted down to a line index; missing top bits are zero.
  assign fld_d = bus_wdata[LINV_DLSB +: LINV_FIELD_W] >> LINE_LOG2;
  assign fld_i = bus_wdata[LINV_ILSB +: LINV_FIELD_W] >> LINE_LOG2;
  assign linv_idx[SIDE_D] = IDX_W'(fld_d);
  assign linv_idx[SIDE_I] = IDX_W'(fld_i);

  assign area_map = map_q;
  assign enable   = ctl_q[CTL_EN];

  always_comb begin
    unique case (bus_addr)
      OFF_AREA: bus_rdata = 32'(map_q);
      OFF_CTRL: bus_rdata = 32'(ctl_q);
      OFF_LINV: bus_rdata = inv_q;
      default:  bus_rdata = '0;
    endcase
  end

  p_ctrl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> (bus_rdata[CTL_W-1:0] == $past(bus_wdata[CTL_W-1:0])) || (bus_addr != OFF_CTRL));
endmodule

// File: rtl/cmaint_valid_store.sv
module cmaint_valid_store
  import cmaint_pkg::*;
#(
  parameter int LINES = 128,
  parameter int IDX_W = $clog2(LINES)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NSIDE-1:0]             clean_pulse,
  input  logic [NSIDE-1:0]             linv_pulse,
  input  logic [NSIDE-1:0][IDX_W-1:0]  linv_idx,
  input  logic                         fill_valid,
  input  logic                         fill_side,
  input  logic [IDX_W-1:0]             fill_index,
  output logic [NSIDE-1:0][LINES-1:0]  vld
);
  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    logic fill_here;
    assign fill_here = fill_valid && (fill_side == 1'(s));

    // Later assignments win: clean over line invalidate over refill.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld[s] <= '0;
      end else begin
        if (fill_here)      vld[s][fill_index]  <= 1'b1;
        if (linv_pulse[s])  vld[s][linv_idx[s]] <= 1'b0;
        if (clean_pulse[s]) vld[s]              <= '0;
      end
    end

    p_clean_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clean_pulse[s] |=> (vld[s] == '0));
    p_line_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      linv_pulse[s] |=> !vld[s][$past(linv_idx[s])]);
    p_fill_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_here && !clean_pulse[s] && !(linv_pulse[s] && linv_idx[s] == fill_index))
        |=> vld[s][$past(fill_index)]);
  end
endmodule

// File: rtl/cmaint_lookup.sv
module cmaint_lookup
  import cmaint_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int REGION_LOG2 = 15,
  parameter int LINE_LOG2   = 5,
  parameter int LINES       = 128,
  parameter int IDX_W       = $clog2(LINES),
  parameter int MAP_W       = 1 << (ADDR_W - REGION_LOG2)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         enable,
  input  logic [MAP_W-1:0]             area_map,
  input  logic [NSIDE-1:0][LINES-1:0]  vld,
  input  logic [ADDR_W-1:0]            lk_addr,
  input  logic                         lk_side,
  output logic                         lk_cacheable,
  output logic                         lk_hit_ok
);
  localparam int REG_W = ADDR_W - REGION_LOG2;

  logic [REG_W-1:0] region;
  logic [IDX_W-1:0] line;
  logic             line_vld;

  assign region       = lk_addr[ADDR_W-1:REGION_LOG2];
  assign line         = lk_addr[LINE_LOG2 +: IDX_W];
  assign line_vld     = vld[lk_side][line];
  assign lk_cacheable = enable && area_map[region];
  assign lk_hit_ok    = lk_cacheable && line_vld;

  p_hit_needs_enable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit_ok |-> enable);
endmodule

// File: rtl/cmaint_unit.sv
module cmaint_unit
  import cmaint_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int REGION_LOG2 = 15,
  parameter int LINE_LOG2   = 5,
  parameter int LINES       = 128,
  parameter int IDX_W       = $clog2(LINES),
  parameter int MAP_W       = 1 << (ADDR_W - REGION_LOG2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [11:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              fill_valid,
  input  logic              fill_side,
  input  logic [IDX_W-1:0]  fill_index,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              lk_side,
  output logic              lk_cacheable,
  output logic              lk_hit_ok
);
  logic [MAP_W-1:0]            area_map;
  logic                        enable;
  logic [NSIDE-1:0]            clean_pulse, linv_pulse;
  logic [NSIDE-1:0][IDX_W-1:0] linv_idx;
  logic [NSIDE-1:0][LINES-1:0] vld;

  cmaint_regs #(.MAP_W(MAP_W), .IDX_W(IDX_W), .LINE_LOG2(LINE_LOG2)) i_regs (
    .clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .area_map, .enable, .clean_pulse, .linv_pulse, .linv_idx
  );

  cmaint_valid_store #(.LINES(LINES), .IDX_W(IDX_W)) i_store (
    .clk, .rst_n, .clean_pulse, .linv_pulse, .linv_idx,
    .fill_valid, .fill_side, .fill_index, .vld
  );

  cmaint_lookup #(.ADDR_W(ADDR_W), .REGION_LOG2(REGION_LOG2), .LINE_LOG2(LINE_LOG2),
                  .LINES(LINES), .IDX_W(IDX_W), .MAP_W(MAP_W)) i_lookup (
    .clk, .rst_n, .enable, .area_map, .vld, .lk_addr, .lk_side, .lk_cacheable, .lk_hit_ok
  );

  p_reset_clear_r1: assert property (@(posedge clk) $rose(rst_n) |-> !lk_cacheable && bus_rdata == '0);
endmodule

// File: tb/test_cmaint_unit.sv
module test_cmaint_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        fill_valid = 1'b0;
  logic        fill_side = 1'b0;
  logic [6:0]  fill_index = '0;
  logic [19:0] lk_addr = '0;
  logic        lk_side = 1'b0;
  logic        lk_cacheable, lk_hit_ok;

  int n_chk = 0, n_bad = 0, cycles = 0;
  string cur_req = "R1";

  bit mv [2][128];
  int unsigned mmap = 0, mctrl = 0, minv = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmaint_unit i_cmaint_unit (.*);

  task automatic check(input string req, input int unsigned act, input int unsigned exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: refill applied first, clears after it.
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      foreach (mv[s, i]) mv[s][i] = 1'b0;
      mmap = 0; mctrl = 0; minv = 0;
    end else begin
      if (fill_valid) mv[fill_side][fill_index] = 1'b1;
      if (bus_wr) begin
        if (bus_addr == 12'hA50) mmap = bus_wdata;
        if (bus_addr == 12'hA54) begin
          if (bus_wdata[31] && !minv[31]) mv[0][(bus_wdata >> 21) % 64] = 1'b0;
          if (bus_wdata[15] && !minv[15]) mv[1][(bus_wdata >> 5) % 64] = 1'b0;
          minv = bus_wdata;
        end
        if (bus_addr == 12'hA58) begin
          if (bus_wdata[1] && !mctrl[1]) foreach (mv[0][i]) mv[0][i] = 1'b0;
          if (bus_wdata[2] && !mctrl[2]) foreach (mv[1][i]) mv[1][i] = 1'b0;
          mctrl = bus_wdata % 8;
        end
      end
    end
  end

  always @(negedge clk) begin
    int unsigned ec, eh, er;
    ec = ((mctrl % 2) == 1 && ((mmap >> (lk_addr / 32768)) % 2) == 1) ? 1 : 0;
    eh = (ec == 1 && mv[lk_side][(lk_addr / 32) % 128]) ? 1 : 0;
    er = (bus_addr == 12'hA50) ? mmap : (bus_addr == 12'hA54) ? minv :
         (bus_addr == 12'hA58) ? mctrl : 0;
    check(cur_req, lk_cacheable, ec, "cacheable");
    check(cur_req, lk_hit_ok, eh, "hit_ok");
    check(cur_req, bus_rdata, er, "rdata");
  end

  task automatic step();
    @(posedge clk); #1;
    bus_wr = 1'b0; fill_valid = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step();
  endtask

  task automatic fill(input logic s, input int idx);
    fill_valid = 1'b1; fill_side = s; fill_index = 7'(idx);
    step();
  endtask

  task automatic look(input logic s, input int idx, input int region);
    lk_side = s; lk_addr = 20'(region * 32768 + idx * 32);
    step();
  endtask

  initial begin
    cur_req = "R1";
    repeat (3) step();
    rst_n = 1'b1;
    look(0, 0, 0); look(1, 5, 3);
    bus_addr = 12'hA50; step(); check("R1", bus_rdata, 0, "area reset");
    bus_addr = 12'hA58; step(); check("R1", bus_rdata, 0, "ctrl reset");

    cur_req = "R2";
    wr(12'hA50, 32'h8000_0005); bus_addr = 12'hA50; step();
    check("R2", bus_rdata, 32'h8000_0005, "area readback");
    wr(12'hA58, 32'hFFFF_FFF9); bus_addr = 12'hA58; step();
    check("R2", bus_rdata, 1, "ctrl readback");
    wr(12'hA54, 32'h0123_4567); bus_addr = 12'hA54; step();
    wr(12'hA54, 32'h0); bus_addr = 12'h100; step();

    cur_req = "R3";
    for (int r = 0; r < 32; r++) look(0, 1, r);
    wr(12'hA58, 0); look(0, 1, 0); look(0, 1, 2);
    wr(12'hA58, 1); wr(12'hA50, 32'hFFFF_FFFF);

    cur_req = "R4";
    fill(0, 3); fill(0, 127); fill(1, 3); fill(1, 64);
    look(0, 3, 0); look(0, 127, 7); look(1, 3, 1); look(1, 64, 2); look(0, 4, 0); look(1, 127, 0);
    check("R4", lk_hit_ok, 0, "instr 127 unfilled");

    cur_req = "R5";
    wr(12'hA58, 3); look(0, 3, 0); look(0, 127, 0); look(1, 3, 0);
    check("R5", lk_hit_ok, 1, "instr survives data clean");

    cur_req = "R7";
    fill(0, 3); wr(12'hA58, 3); look(0, 3, 0);
    check("R7", lk_hit_ok, 1, "repeat clean no effect");

    cur_req = "R6";
    wr(12'hA58, 1); wr(12'hA58, 5); look(1, 3, 0); look(1, 64, 0); look(0, 3, 0);
    check("R6", lk_hit_ok, 1, "data survives instr clean");

    cur_req = "R8";
    fill(0, 5); fill(0, 69); fill(0, 6); fill(1, 5);
    wr(12'hA54, 0); wr(12'hA54, 32'h8000_0000 | (32'hA0 << 16));
    look(0, 5, 0); check("R8", lk_hit_ok, 0, "data line 5 cleared");
    look(0, 69, 0); check("R8", lk_hit_ok, 1, "line 69 kept, top bit zero");
    look(0, 6, 0); look(1, 5, 0);

    cur_req = "R9";
    fill(1, 69);
    wr(12'hA54, 0); wr(12'hA54, 32'h0000_8000 | 32'h7A0);
    look(1, 61, 0); look(1, 5, 0); look(1, 69, 0);
    fill(1, 61); look(1, 61, 0);
    check("R9", lk_hit_ok, 1, "instr refill after invalidate");
    wr(12'hA54, 0); wr(12'hA54, 32'h0000_8000 | 32'h7A0);
    look(1, 61, 0); check("R9", lk_hit_ok, 0, "instr line 61 cleared");

    cur_req = "R10";
    fill(1, 61); fill(0, 5);
    wr(12'hA54, 32'h0000_8000 | 32'h7A0); look(1, 61, 0);
    check("R10", lk_hit_ok, 1, "repeat instr command ignored");
    wr(12'hA54, 32'h8000_8000 | (32'hA0 << 16) | 32'h7A0); look(0, 5, 0);
    look(1, 61, 0);

    cur_req = "R11";
    wr(12'hA54, 0);
    fill_valid = 1'b1; fill_side = 1'b0; fill_index = 7'd9;
    wr(12'hA54, 32'h8000_0000 | (32'h120 << 16));
    look(0, 9, 0); check("R11", lk_hit_ok, 0, "invalidate beats same-index refill");
    wr(12'hA54, 0);
    fill_valid = 1'b1; fill_side = 1'b0; fill_index = 7'd10;
    wr(12'hA54, 32'h8000_0000 | (32'h120 << 16));
    look(0, 10, 0); check("R11", lk_hit_ok, 1, "other-index refill proceeds");
    wr(12'hA58, 1);
    fill_valid = 1'b1; fill_side = 1'b1; fill_index = 7'd20;
    wr(12'hA58, 5);
    look(1, 20, 0); look(0, 10, 0);

    cur_req = "R12";
    wr(12'hA58, 0); look(0, 10, 0);
    check("R12", lk_cacheable, 0, "disabled not cacheable");
    look(1, 61, 0);
    wr(12'hA58, 1); look(0, 10, 0);
    check("R12", lk_hit_ok, 1, "valid kept over disable");

    step();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    wait (cycles > 5000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected<5000 cycles", cycles);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule